// File: doc/BRIEF.md
# Segmented Register-Bus Address Multiplexer

This block sits between a CPU-facing bus arbiter and a set of memory-mapped cores. Each bus cycle carries a 17-bit word address, which the block splits three ways. The top three bits pick a segment: hash, RNG or cipher. Inside the hash segment, the next six bits pick a core slot and the low eight bits pick a register in that slot. Writes go out to the selected core through a one-hot chip-select and shared write lines. Read data from the selected source is captured in a register, so it appears on the bus one clock after the read request.

Hash slot 0 holds no engine. It is a page of board-level registers: two fixed identification words and one scratch word that software can write and read back. The RNG and cipher segments are placeholder templates, each with three fixed dummy words. A build-time mask decides which hash slots are populated. Any address that hits nothing is treated quietly: a write to it is dropped and a read returns zero. The block raises no error signal.

Top module: `regbus_seg_mux`

## Requirements
- R1: Word address bits [16:14] select the segment (0 = hash, 1 = RNG, 2 = cipher, 3 to 7 unmapped). In the hash segment, bits [13:8] select the slot and bits [7:0] the register. core_addr_o carries addr_i[7:0], core_wdata_o carries wdata_i and core_we_o carries we_i, all in the same cycle.
- R2: core_cs_o[k] is high in the same cycle exactly when sel_i is high, the segment is hash, the slot is k, k is not 0, k < NUM_SLOTS and SLOT_EN[k] is set. At most one bit is high at a time.
- R3: A read (sel_i high, we_i low) in cycle n makes rdata_o in cycle n+1 equal to the value that the selected core drove on its core_rdata_i lane in cycle n.
- R4: In any cycle with no read, rdata_o is 0 in the following cycle.
- R5: Hash slot 0 word 0x00 reads 0x50565431 and word 0x01 reads 0x0001000B.
- R6: Hash slot 0 word 0xFF is a 32-bit scratch register. It resets to 0 and returns the last value written to it.
- R7: Writes to the identification words and to the template words do not change what those words read.
- R8: RNG segment words 0, 1 and 2 (addr[13:0]) read 0xAAAAAAAA, 0xBBBBBBBB and 0xCCCCCCCC. Cipher segment words 0, 1 and 2 read 0xDDDDDDDD, 0xEEEEEEEE and 0xFFFFFFFF. All other template words read 0.
- R9: Reads return 0 from unmapped segments, from slots at or above NUM_SLOTS, from slots disabled in SLOT_EN and from unused words of the board page.
- R10: A write to a disabled, out-of-range or unmapped location asserts no chip-select, so it is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Bus cycle valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| core_cs_o | output | NUM_SLOTS | Per-slot chip-select |
| core_we_o | output | 1 | Shared write enable to cores |
| core_addr_o | output | 8 | Register address to cores |
| core_wdata_o | output | 32 | Write data to cores |
| core_rdata_i | input | NUM_SLOTS*32 | Combinational read data, one 32-bit lane per slot |

## Verification
The chip-select and the core-facing address, data and write lines are combinational. The bench checks them one nanosecond after it drives the inputs at the falling edge, within the same cycle. Read data passes through exactly one register, so the bench checks rdata_o at the falling edge that follows the rising edge that accepted the read. It checks again one cycle later to confirm that the output returns to zero. The scratch model in the bench updates only after the write has passed through a rising edge, so a read straight after a write expects the new value.

// File: rtl/regbus_pkg.sv
package regbus_pkg;
  localparam int ADDR_W  = 17;
  localparam int DATA_W  = 32;
  localparam int REG_W   = 8;
  localparam int SLOT_W  = 6;
  localparam int SEG_W   = 3;
  localparam int SEG_LSB = SLOT_W + REG_W;
  localparam int WORD_W  = SEG_LSB;

  typedef enum logic [SEG_W-1:0] {
    SEG_HASH   = 3'd0,
    SEG_RNG    = 3'd1,
    SEG_CIPHER = 3'd2
  } seg_e;

  localparam logic [DATA_W-1:0] BOARD_ID_VAL  = 32'h5056_5431;
  localparam logic [DATA_W-1:0] BITSTREAM_VAL = 32'h0001_000B;
  localparam logic [REG_W-1:0]  ID_WORD       = 8'h00;
  localparam logic [REG_W-1:0]  VER_WORD      = 8'h01;
  localparam logic [REG_W-1:0]  SCRATCH_WORD  = 8'hFF;

  typedef struct packed {
    logic              hash_hit;
    logic              board_hit;
    logic              rng_hit;
    logic              cipher_hit;
    logic [SLOT_W-1:0] slot;
    logic [REG_W-1:0]  reg_addr;
    logic [WORD_W-1:0] seg_word;
  } dec_t;
endpackage

// File: rtl/regbus_addr_dec.sv
module regbus_addr_dec
  import regbus_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic [SEG_W-1:0] seg;

  always_comb begin
    seg              = addr_i[ADDR_W-1:SEG_LSB];
    dec_o.hash_hit   = (seg == SEG_HASH);
    dec_o.rng_hit    = (seg == SEG_RNG);
    dec_o.cipher_hit = (seg == SEG_CIPHER);
    dec_o.slot       = addr_i[SEG_LSB-1:REG_W];
    dec_o.reg_addr   = addr_i[REG_W-1:0];
    dec_o.seg_word   = addr_i[WORD_W-1:0];
    dec_o.board_hit  = dec_o.hash_hit && (dec_o.slot == '0);
  end
endmodule

// File: rtl/regbus_board_page.sv
module regbus_board_page
  import regbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              wr_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] scratch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   scratch_q <= '0;
    else if (hit_i && wr_i && reg_i == SCRATCH_WORD) scratch_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      unique case (reg_i)
        ID_WORD:      rdata_o = BOARD_ID_VAL;
        VER_WORD:     rdata_o = BITSTREAM_VAL;
        SCRATCH_WORD: rdata_o = scratch_q;
        default:      rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/regbus_tmpl_seg.sv
module regbus_tmpl_seg
  import regbus_pkg::*;
#(
  parameter logic [7:0] FIRST_BYTE  = 8'hAA,
  parameter int         DUMMY_WORDS = 3
) (
  input  logic              hit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int BYTES = DATA_W / 8;
  logic [7:0] fill;

  // each dummy word repeats one byte; the byte steps by 0x11 per word
  always_comb begin
    fill    = FIRST_BYTE + 8'(8'h11 * word_i[7:0]);
    rdata_o = '0;
    if (hit_i && word_i < WORD_W'(DUMMY_WORDS)) rdata_o = {BYTES{fill}};
  end
endmodule

// File: rtl/regbus_seg_mux.sv
module regbus_seg_mux
  import regbus_pkg::*;
#(
  parameter int                   NUM_SLOTS = 4,
  parameter logic [NUM_SLOTS-1:0] SLOT_EN   = 4'b1011
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sel_i,
  input  logic                        we_i,
  input  logic [16:0]                 addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic [NUM_SLOTS-1:0]        core_cs_o,
  output logic                        core_we_o,
  output logic [7:0]                  core_addr_o,
  output logic [31:0]                 core_wdata_o,
  input  logic [NUM_SLOTS*32-1:0]     core_rdata_i
);
  dec_t              dec;
  logic              rd_take;
  logic [DATA_W-1:0] board_rdata, rng_rdata, cipher_rdata, core_rdata, rd_next, rdata_q;
  logic [NUM_SLOTS-1:0] slot_cs;

  regbus_addr_dec u_dec (.addr_i(addr_i), .dec_o(dec));

  assign rd_take = sel_i & ~we_i;

  // slot 0 is the board page; other slots exist only when enabled
  assign slot_cs[0] = 1'b0;
  for (genvar k = 1; k < NUM_SLOTS; k++) begin : g_slot
    if (SLOT_EN[k]) begin : g_on
      assign slot_cs[k] = sel_i & dec.hash_hit & (dec.slot == SLOT_W'(k));
    end else begin : g_off
      assign slot_cs[k] = 1'b0;
    end
  end

  regbus_board_page u_board (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (sel_i & dec.board_hit),
    .wr_i   (we_i),
    .reg_i  (dec.reg_addr),
    .wdata_i(wdata_i),
    .rdata_o(board_rdata)
  );

  regbus_tmpl_seg #(.FIRST_BYTE(8'hAA), .DUMMY_WORDS(3)) u_rng (
    .hit_i  (dec.rng_hit),
    .word_i (dec.seg_word),
    .rdata_o(rng_rdata)
  );

  regbus_tmpl_seg #(.FIRST_BYTE(8'hDD), .DUMMY_WORDS(3)) u_cipher (
    .hit_i  (dec.cipher_hit),
    .word_i (dec.seg_word),
    .rdata_o(cipher_rdata)
  );

  always_comb begin
    core_rdata = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (slot_cs[k]) core_rdata = core_rdata | core_rdata_i[k*DATA_W +: DATA_W];
  end

  // sources are mutually exclusive by decode, so an OR merge suffices
  always_comb begin
    rd_next = '0;
    if (rd_take) rd_next = board_rdata | rng_rdata | cipher_rdata | core_rdata;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_next;
  end

  assign rdata_o      = rdata_q;
  assign core_cs_o    = slot_cs;
  assign core_we_o    = we_i;
  assign core_addr_o  = dec.reg_addr;
  assign core_wdata_o = wdata_i;
endmodule

// File: rtl/regbus_seg_mux_chk.sv
module regbus_seg_mux_chk #(
  parameter int NUM_SLOTS = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sel_i,
  input logic                    we_i,
  input logic [16:0]             addr_i,
  input logic [31:0]             rdata_o,
  input logic [NUM_SLOTS-1:0]    core_cs_o,
  input logic [NUM_SLOTS*32-1:0] core_rdata_i
);
  logic [31:0] pick;
  always_comb begin
    pick = '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (core_cs_o[k]) pick = pick | core_rdata_i[k*32 +: 32];
  end

  assert_cs_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(core_cs_o));
  assert_cs_needs_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_cs_o != '0) |-> sel_i);
  assert_no_cs_slot0_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_cs_o[0] == 1'b0);
  assert_core_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && core_cs_o != '0) |=> rdata_o == $past(pick));
  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && !we_i) |=> rdata_o == 32'h0);
  assert_board_id_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i == 17'h00000) |=> rdata_o == 32'h5056_5431);
  assert_rng_word0_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i == 17'h04000) |=> rdata_o == 32'hAAAA_AAAA);
  assert_unmapped_seg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i[16:14] > 3'd2) |=> rdata_o == 32'h0);
endmodule

bind regbus_seg_mux regbus_seg_mux_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sel_i       (sel_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .core_cs_o   (core_cs_o),
  .core_rdata_i(core_rdata_i)
);

// File: tb/regbus_seg_mux_bench.sv
`timescale 1ns/1ps
module regbus_seg_mux_bench;
  localparam int           NS = 4;
  localparam logic [NS-1:0] EN = 4'b1011;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [16:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NS-1:0] cs;
  logic c_we;
  logic [7:0] c_addr;
  logic [31:0] c_wdata;
  logic [NS*32-1:0] c_rdata;

  int n_chk = 0, n_fail = 0;
  logic [31:0] scratch_m = '0;

  always #5 clk = ~clk;

  regbus_seg_mux #(.NUM_SLOTS(NS), .SLOT_EN(EN)) u_regbus_seg_mux (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .core_cs_o(cs), .core_we_o(c_we),
    .core_addr_o(c_addr), .core_wdata_o(c_wdata), .core_rdata_i(c_rdata)
  );

  // stand-in cores: every lane, including slot 0 and disabled slots, drives data
  function automatic logic [31:0] core_val(int k, logic [7:0] r);
    return {4'hC, 4'(k), 16'h5A00, r};
  endfunction

  always_comb
    for (int k = 0; k < NS; k++) c_rdata[k*32 +: 32] = core_val(k, c_addr);

  function automatic logic [NS-1:0] exp_cs(logic s, logic [16:0] a);
    int sl = int'(a[13:8]);
    if (s && a[16:14] == 3'd0 && sl != 0 && sl < NS && EN[sl]) return NS'(1) << sl;
    return '0;
  endfunction

  function automatic logic [31:0] exp_rd(logic [16:0] a);
    int sl = int'(a[13:8]);
    logic [7:0] r = a[7:0];
    case (a[16:14])
      3'd0: begin
        if (sl == 0) begin
          if (r == 8'h00) return 32'h5056_5431;
          if (r == 8'h01) return 32'h0001_000B;
          if (r == 8'hFF) return scratch_m;
          return 32'h0;
        end
        if (sl < NS && EN[sl]) return core_val(sl, r);
        return 32'h0;
      end
      3'd1: return (a[13:0] < 14'd3) ? {4{8'hAA + 8'(8'h11 * a[7:0])}} : 32'h0;
      3'd2: return (a[13:0] < 14'd3) ? {4{8'hDD + 8'(8'h11 * a[7:0])}} : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [16:0] a, logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1;
    check(cs == exp_cs(1'b1, a), "R2/R10 cs", 32'(cs), 32'(exp_cs(1'b1, a)));
    check(c_we && c_addr == a[7:0] && c_wdata == d, "R1 core lines",
          {c_addr, 23'h0, c_we}, {a[7:0], 23'h0, 1'b1});
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    if (a[16:8] == 9'h0 && a[7:0] == 8'hFF) scratch_m = d;
  endtask

  task automatic do_read(logic [16:0] a, string req);
    logic [31:0] e;
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    check(cs == exp_cs(1'b1, a), "R2 cs on read", 32'(cs), 32'(exp_cs(1'b1, a)));
    e = exp_rd(a);
    @(negedge clk);
    sel = 1'b0;
    check(rdata == e, req, rdata, e);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(rdata == 32'h0 && cs == '0, "R4 reset state", rdata, 32'h0);
    rst_ni = 1'b1;
    do_read(17'h000FF, "R6 scratch reset");
    do_read(17'h00000, "R5 board id");
    do_read(17'h00001, "R5 bitstream");
    @(negedge clk);
    check(rdata == 32'h0, "R4 idle after read", rdata, 32'h0);
    do_write(17'h000FF, 32'hDEAD_BEEF);
    do_read(17'h000FF, "R6 scratch readback");
    do_write(17'h00000, 32'h1234_5678);
    do_write(17'h00001, 32'h0);
    do_read(17'h00000, "R7 id unchanged");
    do_read(17'h00001, "R7 ver unchanged");
    do_write(17'h04000, 32'h0);
    do_write(17'h08002, 32'h1);
    for (int i = 0; i < 3; i++) begin
      do_read(17'h04000 + 17'(i), "R8 rng word");
      do_read(17'h08000 + 17'(i), "R8 cipher word");
    end
    do_read(17'h04003, "R8 rng unused");
    do_read(17'h00105, "R3 slot1 read");
    do_read(17'h003A0, "R3 slot3 read");
    do_read(17'h00210, "R9 disabled slot");
    do_read(17'h00410, "R9 slot beyond range");
    do_read(17'h00042, "R9 unused board word");
    do_read(17'h0C000, "R9 segment 3");
    do_read(17'h1C001, "R9 segment 7");
    do_write(17'h00210, 32'h5555_5555);
    do_write(17'h0C000, 32'h6666_6666);
    do_read(17'h000FF, "R10 scratch untouched");
    for (int i = 0; i < 400; i++) begin
      logic [16:0] a;
      logic [7:0] r;
      case ($urandom % 5)
        0: r = 8'h00;
        1: r = 8'h01;
        2: r = 8'hFF;
        3: r = 8'($urandom % 4);
        default: r = 8'($urandom);
      endcase
      a = {3'($urandom % 5 == 4 ? 7 : $urandom % 4), 6'($urandom % 6), r};
      if (a[16:14] != 3'd0) a[13:8] = ($urandom % 2 == 0) ? 6'd0 : a[13:8];
      if ($urandom % 2 == 0) do_write(a, $urandom);
      else                   do_read(a, "R3/R9 random read");
    end
    @(negedge clk);
    check(rdata == 32'h0, "R4 final idle", rdata, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule